// File: doc/BRIEF.md
# Byte-Lane Register Window Decoder

This block fronts a 128-byte little-endian I/O window of a storage adapter. A host issues reads and writes of 1, 2 or 4 bytes at any byte address. The decoder turns each one into a full, aligned 32-bit access on one of three register targets: the SCSI core register file, the DMA register file, or a single bus-and-control word. The targets sit outside this block and appear only as simple ports, each with a word index, an asynchronous read word and a write strobe.

A narrow or unaligned write becomes a read-modify-write. The current word of the target is read, the new bytes are placed into the byte lanes that start at the byte offset of the address, and the merged word is written back in the same cycle. A read selects the word, shifts it down by the byte offset and masks it to the requested size. The result is returned one cycle later. Addresses that map to no target read as zero, and writes to them are dropped.

Top module: `regwin_lane_decoder`

## Requirements
- R1: While reset is held and right after it is released, rsp_valid is 0 and rsp_rdata is zero.
- R2: A byte address from 0x00 to 0x3F selects the SCSI core file at word index address[5:2].
- R3: A byte address from 0x40 to 0x5F selects the DMA file at word index (address - 0x40) >> 2.
- R4: A write whose word-aligned address is 0x70 (byte addresses 0x70 to 0x73) updates the bus-and-control word. Only a read at exactly 0x70 returns that word.
- R5: req_size encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. A write places its low bytes into the lanes starting at address[1:0] and drops any byte that would fall beyond lane 3. Every other lane keeps the target's current value. The merged full word is written in the same cycle as the request.
- R6: Read data equals the selected word shifted right by 8 x address[1:0], with all bits at or above 8 x size cleared.
- R7: Each read produces exactly one rsp_valid pulse in the cycle after the request, and responses come in request order. A write produces no response.
- R8: A read at 0x60 to 0x6F, 0x71 to 0x7F returns zero.
- R9: A write at 0x60 to 0x6F or 0x74 to 0x7F raises no write strobe and changes no target.
- R10: At most one target write strobe is high in a cycle, and none is high without a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address within the window |
| req_size | input | 2 | Access width code (see R5) |
| req_wdata | input | DATA_W | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Aligned and masked read data |
| core_idx | output | CORE_IDX_W | SCSI core file word index |
| core_we | output | 1 | SCSI core file write strobe |
| core_wdata | output | DATA_W | Merged word for the SCSI core file |
| core_rdata | input | DATA_W | Current SCSI core word at core_idx |
| dma_idx | output | DMA_IDX_W | DMA file word index |
| dma_we | output | 1 | DMA file write strobe |
| dma_wdata | output | DATA_W | Merged word for the DMA file |
| dma_rdata | input | DATA_W | Current DMA word at dma_idx |
| ctl_we | output | 1 | Bus-and-control write strobe |
| ctl_wdata | output | DATA_W | Merged bus-and-control word |
| ctl_rdata | input | DATA_W | Current bus-and-control word |

## Verification
The assertions check on every cycle that at most one strobe fires, that no strobe fires without a write request or at a gap address, and that each read gets exactly one response on the next cycle. They also check that byte reads come back masked, that gap reads return zero, and that an aligned byte write keeps the upper lanes of the core word. Only the bench scenarios can show that merged bytes land in the correct lanes and that the correct word index is hit in each sub-region. The same holds for lanes beyond lane 3 being dropped, for the 0x70 read/write asymmetry, and for back-to-back write-then-read ordering. The bench shows these by reading every word back through the window.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CORE = 2'd1,
    TGT_DMA  = 2'd2,
    TGT_CTL  = 2'd3
  } tgt_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/regwin_addr_decode.sv
module regwin_addr_decode
  import regwin_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int CORE_IDX_W = 4,
  parameter int DMA_IDX_W  = 3,
  parameter int CTL_ADDR   = 'h70
) (
  input  logic [ADDR_W-1:0]     addr,
  output tgt_e                  wr_tgt,
  output tgt_e                  rd_tgt,
  output logic [CORE_IDX_W-1:0] core_idx,
  output logic [DMA_IDX_W-1:0]  dma_idx
);
  localparam int CORE_END = 4 << CORE_IDX_W;
  localparam int DMA_END  = CORE_END + (4 << DMA_IDX_W);

  logic [ADDR_W-1:0] dma_off;
  logic [ADDR_W-1:0] word_addr;

  assign dma_off   = addr - ADDR_W'(CORE_END);
  assign word_addr = {addr[ADDR_W-1:2], 2'b00};
  assign core_idx  = addr[CORE_IDX_W+1:2];
  assign dma_idx   = dma_off[DMA_IDX_W+1:2];

  always_comb begin
    if (int'(addr) < CORE_END)            wr_tgt = TGT_CORE;
    else if (int'(addr) < DMA_END)        wr_tgt = TGT_DMA;
    else if (int'(word_addr) == CTL_ADDR) wr_tgt = TGT_CTL;
    else                                  wr_tgt = TGT_NONE;
  end

  always_comb begin
    if (int'(addr) < CORE_END)       rd_tgt = TGT_CORE;
    else if (int'(addr) < DMA_END)   rd_tgt = TGT_DMA;
    else if (int'(addr) == CTL_ADDR) rd_tgt = TGT_CTL;
    else                             rd_tgt = TGT_NONE;
  end
endmodule

// File: rtl/regwin_lane_merge.sv
module regwin_lane_merge
  import regwin_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] merged
);
  logic [LANES-1:0]  size_mask;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] placed;

  always_comb begin
    case (size)
      SZ_BYTE: size_mask = LANES'(1);
      SZ_HALF: size_mask = LANES'(3);
      default: size_mask = '1;
    endcase
  end

  assign lane_en = size_mask << off;
  assign placed  = wdata << {off, 3'b000};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign merged[8*k +: 8] = lane_en[k] ? placed[8*k +: 8] : cur[8*k +: 8];
  end
endmodule

// File: rtl/regwin_read_align.sv
module regwin_read_align
  import regwin_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W / 8)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] aligned
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] keep;

  assign shifted = word >> {off, 3'b000};

  always_comb begin
    case (size)
      SZ_BYTE: keep = {{(DATA_W-8){1'b0}}, 8'hFF};
      SZ_HALF: keep = {{(DATA_W-16){1'b0}}, 16'hFFFF};
      default: keep = '1;
    endcase
  end

  assign aligned = shifted & keep;
endmodule

// File: rtl/regwin_lane_decoder.sv
module regwin_lane_decoder
  import regwin_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int CORE_IDX_W = 4,
  parameter int DMA_IDX_W  = 3,
  parameter int CTL_ADDR   = 'h70
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_size,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [CORE_IDX_W-1:0] core_idx,
  output logic                  core_we,
  output logic [DATA_W-1:0]     core_wdata,
  input  logic [DATA_W-1:0]     core_rdata,
  output logic [DMA_IDX_W-1:0]  dma_idx,
  output logic                  dma_we,
  output logic [DATA_W-1:0]     dma_wdata,
  input  logic [DATA_W-1:0]     dma_rdata,
  output logic                  ctl_we,
  output logic [DATA_W-1:0]     ctl_wdata,
  input  logic [DATA_W-1:0]     ctl_rdata
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  tgt_e              wr_tgt;
  tgt_e              rd_tgt;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] wr_cur;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] aligned;
  logic              wr_fire;
  logic              rd_fire;

  assign off     = req_addr[OFF_W-1:0];
  assign wr_fire = req_valid && req_write;
  assign rd_fire = req_valid && !req_write;

  regwin_addr_decode #(
    .ADDR_W(ADDR_W), .CORE_IDX_W(CORE_IDX_W),
    .DMA_IDX_W(DMA_IDX_W), .CTL_ADDR(CTL_ADDR)
  ) dec_i (
    .addr(req_addr), .wr_tgt(wr_tgt), .rd_tgt(rd_tgt),
    .core_idx(core_idx), .dma_idx(dma_idx)
  );

  always_comb begin
    case (wr_tgt)
      TGT_CORE: wr_cur = core_rdata;
      TGT_DMA:  wr_cur = dma_rdata;
      TGT_CTL:  wr_cur = ctl_rdata;
      default:  wr_cur = '0;
    endcase
  end

  regwin_lane_merge #(.DATA_W(DATA_W)) merge_i (
    .cur(wr_cur), .wdata(req_wdata), .off(off),
    .size(req_size), .merged(merged)
  );

  assign core_we    = wr_fire && (wr_tgt == TGT_CORE);
  assign dma_we     = wr_fire && (wr_tgt == TGT_DMA);
  assign ctl_we     = wr_fire && (wr_tgt == TGT_CTL);
  assign core_wdata = merged;
  assign dma_wdata  = merged;
  assign ctl_wdata  = merged;

  always_comb begin
    case (rd_tgt)
      TGT_CORE: rd_word = core_rdata;
      TGT_DMA:  rd_word = dma_rdata;
      TGT_CTL:  rd_word = ctl_rdata;
      default:  rd_word = '0;
    endcase
  end

  regwin_read_align #(.DATA_W(DATA_W)) align_i (
    .word(rd_word), .off(off), .size(req_size), .aligned(aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= aligned;
    end
  end
endmodule

// File: rtl/regwin_lane_decoder_chk.sv
module regwin_lane_decoder_chk #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int CORE_IDX_W = 4,
  parameter int DMA_IDX_W  = 3,
  parameter int CTL_ADDR   = 'h70
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              core_we,
  input logic [DATA_W-1:0] core_wdata,
  input logic [DATA_W-1:0] core_rdata,
  input logic              dma_we,
  input logic              ctl_we
);
  localparam int CORE_END = 4 << CORE_IDX_W;
  localparam int DMA_END  = CORE_END + (4 << DMA_IDX_W);

  logic wr_req, rd_req, gap_wr, gap_rd;
  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;
  assign gap_wr = (int'(req_addr) >= DMA_END) &&
                  (int'({req_addr[ADDR_W-1:2], 2'b00}) != CTL_ADDR);
  assign gap_rd = (int'(req_addr) >= DMA_END) && (int'(req_addr) != CTL_ADDR);

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({core_we, dma_we, ctl_we}));

  assert_no_strobe_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_req |-> !(core_we || dma_we || ctl_we));

  assert_gap_write_dropped_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_req && gap_wr) |-> !(core_we || dma_we || ctl_we));

  assert_rsp_follows_read_R7: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);

  assert_no_rsp_otherwise_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rsp_valid);

  assert_byte_read_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_size == 2'd0) |=> (rsp_rdata[DATA_W-1:8] == '0));

  assert_gap_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && gap_rd) |=> (rsp_rdata == '0));

  assert_byte_merge_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (core_we && req_size == 2'd0 && req_addr[1:0] == 2'd0) |->
      (core_wdata[DATA_W-1:8] == core_rdata[DATA_W-1:8]));
endmodule

bind regwin_lane_decoder regwin_lane_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CORE_IDX_W(CORE_IDX_W),
  .DMA_IDX_W(DMA_IDX_W), .CTL_ADDR(CTL_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .core_we(core_we), .core_wdata(core_wdata),
  .core_rdata(core_rdata), .dma_we(dma_we), .ctl_we(ctl_we)
);

// File: tb/regwin_lane_decoder_tb_top.sv
module regwin_lane_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  core_idx;
  logic        core_we, dma_we, ctl_we;
  logic [31:0] core_wdata, dma_wdata, ctl_wdata;
  logic [31:0] core_rdata, dma_rdata, ctl_rdata;
  logic [2:0]  dma_idx;

  always #5 clk = ~clk;

  regwin_lane_decoder dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .core_idx(core_idx), .core_we(core_we), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .dma_idx(dma_idx), .dma_we(dma_we),
    .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
  );

  // Target register files owned by the bench
  logic [31:0] core_mem [16];
  logic [31:0] dma_mem [8];
  logic [31:0] ctl_reg;

  function automatic logic [31:0] core_init(int i);
    return {8'hA0 + 8'(i), 8'hB0 + 8'(i), 8'hC0 + 8'(i), 8'hD0 + 8'(i)};
  endfunction
  function automatic logic [31:0] dma_init(int i);
    return {8'h50 + 8'(i), 8'h60 + 8'(i), 8'h70 + 8'(i), 8'h80 + 8'(i)};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) core_mem[i] <= core_init(i);
      for (int i = 0; i < 8; i++)  dma_mem[i]  <= dma_init(i);
      ctl_reg <= 32'h89AB_CDEF;
    end else begin
      if (core_we) core_mem[core_idx] <= core_wdata;
      if (dma_we)  dma_mem[dma_idx]   <= dma_wdata;
      if (ctl_we)  ctl_reg            <= ctl_wdata;
    end
  end
  assign core_rdata = core_mem[core_idx];
  assign dma_rdata  = dma_mem[dma_idx];
  assign ctl_rdata  = ctl_reg;

  // Shadow state and scoreboard
  logic [31:0] sh_core [16];
  logic [31:0] sh_dma [8];
  logic [31:0] sh_ctl;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int n_checks = 0;
  int n_fail = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] model_read(int a, logic [1:0] sz);
    logic [31:0] w, m;
    if (a < 64)       w = sh_core[a / 4];
    else if (a < 96)  w = sh_dma[(a - 64) / 4];
    else if (a == 112) w = sh_ctl;
    else              w = 32'h0;
    w = w >> (8 * (a % 4));
    m = (nbytes(sz) == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nbytes(sz))) - 32'h1);
    return w & m;
  endfunction

  function automatic logic [31:0] merge_word(logic [31:0] cur, int off, logic [1:0] sz,
                                             logic [31:0] d);
    logic [31:0] r = cur;
    for (int b = 0; b < 4; b++) begin
      int s = b - off;
      if (s >= 0 && s < nbytes(sz)) r[8*b +: 8] = d[8*s +: 8];
    end
    return r;
  endfunction

  task automatic wr(int a, logic [1:0] sz, logic [31:0] d, string req);
    logic [2:0] exp_stb;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = 7'(a); req_size = sz; req_wdata = d;
    exp_stb = 3'b000;
    if (a < 64) begin
      exp_stb = 3'b001;
      sh_core[a / 4] = merge_word(sh_core[a / 4], a % 4, sz, d);
    end else if (a < 96) begin
      exp_stb = 3'b010;
      sh_dma[(a - 64) / 4] = merge_word(sh_dma[(a - 64) / 4], a % 4, sz, d);
    end else if ((a & ~3) == 112) begin
      exp_stb = 3'b100;
      sh_ctl = merge_word(sh_ctl, a % 4, sz, d);
    end
    #1;
    check({req, " R10 strobe"}, {29'h0, ctl_we, dma_we, core_we}, {29'h0, exp_stb});
    if (exp_stb == 3'b001) check("R2 core index", {28'h0, core_idx}, 32'(a / 4));
    if (exp_stb == 3'b010) check("R3 dma index", {29'h0, dma_idx}, 32'((a - 64) / 4));
  endtask

  task automatic rd(int a, logic [1:0] sz, string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0;
    req_addr = 7'(a); req_size = sz; req_wdata = 32'hDEAD_BEEF;
    exp_q.push_back(model_read(a, sz));
    tag_q.push_back(req);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops one expected item per response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected response", rsp_rdata, 32'h0);
        n_fail += (rsp_rdata == 32'h0) ? 1 : 0;
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) sh_core[i] = core_init(i);
    for (int i = 0; i < 8; i++)  sh_dma[i]  = dma_init(i);
    sh_ctl = 32'h89AB_CDEF;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    check("R1 rsp_rdata after reset", rsp_rdata, 32'h0);

    // Full-word reads over all mapped words
    for (int i = 0; i < 16; i++) rd(4 * i, 2'd2, "R2 core word read");
    for (int i = 0; i < 8; i++)  rd(64 + 4 * i, 2'd2, "R3 dma word read");
    rd(112, 2'd2, "R4 ctl word read");
    idle(2);

    // Narrow reads at every offset
    rd(3, 2'd0, "R6 byte lane 3");
    rd(2, 2'd1, "R6 half at offset 2");
    rd(1, 2'd1, "R6 half at offset 1");
    rd(6, 2'd2, "R6 word at offset 2");
    rd(69, 2'd0, "R6 dma byte offset 1");
    rd(9, 2'd3, "R5 size code 3 reads word");
    idle(2);

    // Narrow and unaligned writes to core
    wr(5, 2'd0, 32'h0000_0011, "R5 byte lane 1");
    wr(10, 2'd1, 32'h0000_2233, "R5 half lanes 2-3");
    wr(16, 2'd2, 32'h4455_6677, "R5 full word");
    wr(19, 2'd2, 32'h8899_AABB, "R5 word at offset 3 truncated");
    wr(15, 2'd1, 32'h0000_CCDD, "R5 half at offset 3 truncated");
    wr(20, 2'd0, 32'hFFFF_FF5A, "R5 byte ignores upper data");
    wr(32, 2'd3, 32'h1357_9BDF, "R5 size code 3 writes word");
    rd(4, 2'd2, "R5 readback lane 1");
    rd(8, 2'd2, "R5 readback lanes 2-3");
    rd(12, 2'd2, "R5 readback offset 3 half");
    rd(16, 2'd2, "R5 readback offset 3 word");
    rd(20, 2'd2, "R5 readback byte lane 0");
    rd(32, 2'd2, "R5 readback size 3");
    idle(2);

    // DMA region writes
    wr(71, 2'd0, 32'h0000_00E7, "R3 dma byte lane 3");
    wr(92, 2'd2, 32'hCAFE_F00D, "R3 dma last word");
    wr(66, 2'd1, 32'h0000_ABCD, "R3 dma half offset 2");
    rd(68, 2'd2, "R3 dma readback word 1");
    rd(92, 2'd2, "R3 dma readback word 7");
    rd(64, 2'd2, "R3 dma readback word 0");
    idle(2);

    // Bus-and-control word
    wr(114, 2'd0, 32'h0000_0042, "R4 ctl byte at 0x72");
    wr(113, 2'd1, 32'h0000_9876, "R4 ctl half at 0x71");
    rd(112, 2'd2, "R4 ctl readback");
    rd(113, 2'd0, "R8 read at 0x71 is zero");
    rd(114, 2'd1, "R8 read at 0x72 is zero");
    rd(112, 2'd0, "R4 ctl byte read at 0x70");
    idle(2);

    // Gap writes and reads
    wr(96, 2'd2, 32'h1111_1111, "R9 write 0x60 dropped");
    wr(108, 2'd0, 32'h0000_0022, "R9 write 0x6C dropped");
    wr(116, 2'd2, 32'h3333_3333, "R9 write 0x74 dropped");
    wr(127, 2'd0, 32'h0000_0044, "R9 write 0x7F dropped");
    for (int i = 0; i < 8; i++) rd(64 + 4 * i, 2'd2, "R9 dma unchanged");
    rd(112, 2'd2, "R9 ctl unchanged");
    rd(96, 2'd2, "R8 read 0x60 zero");
    rd(110, 2'd1, "R8 read 0x6E zero");
    rd(120, 2'd2, "R8 read 0x78 zero");
    rd(127, 2'd0, "R8 read 0x7F zero");
    idle(2);

    // Back-to-back write then read of the same word
    wr(40, 2'd0, 32'h0000_0077, "R7 b2b write");
    rd(40, 2'd2, "R7 b2b read sees write");
    wr(41, 2'd0, 32'h0000_0088, "R7 b2b write 2");
    wr(42, 2'd1, 32'h0000_99AA, "R7 b2b write 3");
    rd(40, 2'd2, "R7 b2b merged word");
    idle(4);

    check("R7 all responses arrived", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule